// File: doc/BRIEF.md
# NAND Page ECC Syndrome Corrector

This block checks one 512-byte data block of a NAND page against its Hamming-style error code and repairs a single flipped bit in place. On a start strobe it takes two 24-bit codes: the one stored in the spare area and the one computed over the data just read. It splits each code into twelve even/odd parity pairs and XORs the two sets into a syndrome. From the number of set syndrome bits it decides whether the block is clean, holds one correctable bit error, is a blank (erased) page, or cannot be repaired.

When the verdict is a correctable error, the block finds the failing byte and bit from the odd half of the syndrome. It then performs a read-modify-write on the external data buffer through a byte-wide port to flip that bit. Status is a 2-bit result code, the error location, a busy flag and a one-cycle done pulse. Producing the codes is done elsewhere.

Top module: `nand_ecc_fixer`

## Requirements
- R1: While reset is held and in the cycle after it, busy, done, buf_rd_en and buf_wr_en are low and result is 2'b00.
- R2: When the two codes are equal the result is 2'b00 (clean) and the data buffer is not accessed.
- R3: When the codes differ in exactly one bit the result is 2'b10 (uncorrectable) and the buffer is not accessed.
- R4: When the codes differ in exactly 11 bits the result is 2'b10 (uncorrectable) and the buffer is not accessed.
- R5: Code bit layout: bits [7:0] hold the even parities of P1..P128 (bit k = P(2^k)), bits [15:8] the odd parities of P1..P128, bits [19:16] the even parities of P256..P2048, bits [23:20] the odd parities of P256..P2048. When the codes differ in exactly 12 bits, with syndrome x = stored XOR computed, the result is 2'b01 (corrected), err_byte = {x[23:20], x[15:11]} and err_bit = x[10:8].
- R6: For a corrected error, the buffer byte at err_byte is XORed with 1 shifted left by err_bit, and every other byte keeps its value.
- R7: For any other difference count, a stored code of 24'hFFFFFF with a computed code of zero gives result 2'b11 (erased, no error). Every other such case gives 2'b10. The buffer is not accessed in either case.
- R8: done is a one-cycle pulse. Call the clock edge that samples start edge 0. Without a correction, done is high in the cycle after edge 1. With a correction, it is high in the cycle after edge 3, which is the cycle after the buffer write.
- R9: A start strobe while busy is high is ignored. The running check completes with its own result, and no second check follows.
- R10: A correction makes exactly one read (buf_rd_en for one cycle, read data returned the next cycle) and then exactly one write to the same address. err_byte and err_bit are zero whenever the result is not 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a check with the codes present this cycle |
| code_stored | input | 24 | Code read from the spare area |
| code_calc | input | 24 | Code computed over the data |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse when the check is finished |
| result | output | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 erased |
| err_byte | output | 9 | Offset of the corrected byte |
| err_bit | output | 3 | Index of the corrected bit |
| buf_addr | output | 9 | Data buffer byte address |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rdata | input | 8 | Buffer read data, one cycle after the request |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |

## Verification
The verdict logic is driven with equal codes, single-bit differences, 11-bit differences, true single-error syndromes and unconstrained random syndromes. Together these separate the four verdicts and show that the population count, and not the mere presence of a difference, decides the outcome. Directed cases probe the erased page against near-erased codes (all-ones stored with a nonzero computed code) and the extreme offsets 0 and 511. A start pulse during a correction shows that a busy check cannot be disturbed. A full buffer comparison after every check shows that only the reported bit was flipped.

// File: rtl/ecc_fixer_pkg.sv
// Shared types for the NAND ECC syndrome corrector.
// Assumes nothing beyond a 2-bit verdict encoding seen at the top ports.
package ecc_fixer_pkg;

    // Verdict codes; values are visible on the result port
    typedef enum logic [1:0] {
        OUT_CLEAN  = 2'b00,
        OUT_FIXED  = 2'b01,
        OUT_FATAL  = 2'b10,
        OUT_BLANK  = 2'b11
    } outcome_e;

    // Sequencer states of the corrector
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CLASSIFY = 3'd1,
        ST_FETCH    = 3'd2,
        ST_PATCH    = 3'd3,
        ST_REPORT   = 3'd4
    } fix_state_e;

endpackage

// File: rtl/ecc_code_unpack.sv
// Splits a packed code into its even and odd parity vectors.
// Assumes the packing: low byte even P1..P128, next byte odd P1..P128,
// then the remaining even parities followed by the remaining odd ones.
// For eight or fewer pairs the lower half is even and the upper half odd.
module ecc_code_unpack #(
    parameter int NPAIR = 12
) (
    input  logic [2*NPAIR-1:0] code,
    output logic [NPAIR-1:0]   par_even,
    output logic [NPAIR-1:0]   par_odd
);

    generate
        if (NPAIR <= 8) begin : g_short
            // Short code: halves map directly
            assign par_even = code[NPAIR-1:0];
            assign par_odd  = code[2*NPAIR-1:NPAIR];
        end else begin : g_long
            localparam int HI = NPAIR - 8;
            // First two bytes carry the eight low parity pairs
            assign par_even[7:0] = code[7:0];
            assign par_odd[7:0]  = code[15:8];
            // Third field carries the upper pairs, even nibble first
            assign par_even[NPAIR-1:8] = code[16 +: HI];
            assign par_odd[NPAIR-1:8]  = code[16+HI +: HI];
        end
    endgenerate

endmodule

// File: rtl/ecc_popcount.sv
// Counts the set bits of a vector.
// Assumes CW is wide enough to hold W.
module ecc_popcount #(
    parameter int W  = 24,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    // Sum each bit into the running count
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/ecc_outcome.sv
// Maps the syndrome weight and code flags onto a verdict.
// Assumes weight is the bit count of the full syndrome. The checks are
// ordered: equal codes, weight one, weight NPAIR-1, weight NPAIR, then blank.
module ecc_outcome
    import ecc_fixer_pkg::*;
#(
    parameter int NPAIR = 12,
    parameter int CW    = 5
) (
    input  logic          same,
    input  logic          blank,
    input  logic [CW-1:0] weight,
    output outcome_e      verdict
);

    // Priority classification of the syndrome
    always_comb begin
        if (same || weight == '0) begin
            verdict = OUT_CLEAN;
        end else if (weight == CW'(1)) begin
            verdict = OUT_FATAL;
        end else if (weight == CW'(NPAIR - 1)) begin
            verdict = OUT_FATAL;
        end else if (weight == CW'(NPAIR)) begin
            verdict = OUT_FIXED;
        end else if (blank) begin
            verdict = OUT_BLANK;
        end else begin
            verdict = OUT_FATAL;
        end
    end

endmodule

// File: rtl/nand_ecc_fixer.sv
// NAND ECC syndrome corrector for one data block of 2^BLK_LOG bytes.
// On start it latches the parity syndrome. It classifies the syndrome one
// cycle later and, for a single-bit error, reads and rewrites the failing
// byte. Assumes the buffer returns read data one cycle after buf_rd_en and
// takes a write on the edge where buf_wr_en is high.
module nand_ecc_fixer
    import ecc_fixer_pkg::*;
#(
    parameter int BLK_LOG = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2*(BLK_LOG+3)-1:0]   code_stored,
    input  logic [2*(BLK_LOG+3)-1:0]   code_calc,
    output logic                       busy,
    output logic                       done,
    output logic [1:0]                 result,
    output logic [BLK_LOG-1:0]         err_byte,
    output logic [2:0]                 err_bit,
    output logic [BLK_LOG-1:0]         buf_addr,
    output logic                       buf_rd_en,
    input  logic [7:0]                 buf_rdata,
    output logic                       buf_wr_en,
    output logic [7:0]                 buf_wdata
);

    localparam int NPAIR  = BLK_LOG + 3;
    localparam int CODE_W = 2 * NPAIR;
    localparam int CW     = $clog2(CODE_W + 1);

    fix_state_e         state_q;
    logic [NPAIR-1:0]   st_even, st_odd, ca_even, ca_odd;
    logic [NPAIR-1:0]   syn_even_q, syn_odd_q;
    logic               same_q, blank_q;
    logic [CW-1:0]      weight;
    outcome_e           verdict_d, verdict_q;
    logic [BLK_LOG-1:0] err_byte_q;
    logic [2:0]         err_bit_q;
    logic               accept;

    ecc_code_unpack #(.NPAIR(NPAIR)) u_unpack_stored (
        .code     (code_stored),
        .par_even (st_even),
        .par_odd  (st_odd)
    );

    ecc_code_unpack #(.NPAIR(NPAIR)) u_unpack_calc (
        .code     (code_calc),
        .par_even (ca_even),
        .par_odd  (ca_odd)
    );

    ecc_popcount #(.W(CODE_W), .CW(CW)) u_weight (
        .vec   ({syn_odd_q, syn_even_q}),
        .count (weight)
    );

    ecc_outcome #(.NPAIR(NPAIR), .CW(CW)) u_outcome (
        .same    (same_q),
        .blank   (blank_q),
        .weight  (weight),
        .verdict (verdict_d)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // Sequencer: capture, classify, optional fetch and patch, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:     if (start) state_q <= ST_CLASSIFY;
                ST_CLASSIFY: state_q <= (verdict_d == OUT_FIXED) ? ST_FETCH : ST_REPORT;
                ST_FETCH:    state_q <= ST_PATCH;
                ST_PATCH:    state_q <= ST_REPORT;
                ST_REPORT:   state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the unpacked syndrome and the code flags on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_even_q <= '0;
            syn_odd_q  <= '0;
            same_q     <= 1'b1;
            blank_q    <= 1'b0;
        end else if (accept) begin
            syn_even_q <= st_even ^ ca_even;
            syn_odd_q  <= st_odd ^ ca_odd;
            same_q     <= (code_stored == code_calc);
            blank_q    <= (&code_stored) && !(|code_calc);
        end
    end

    // Register the verdict and the error location after classification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q  <= OUT_CLEAN;
            err_byte_q <= '0;
            err_bit_q  <= '0;
        end else if (state_q == ST_CLASSIFY) begin
            verdict_q <= verdict_d;
            if (verdict_d == OUT_FIXED) begin
                err_byte_q <= syn_odd_q[NPAIR-1:3];
                err_bit_q  <= syn_odd_q[2:0];
            end else begin
                err_byte_q <= '0;
                err_bit_q  <= '0;
            end
        end
    end

    // Buffer port: one read, then a write of the byte with one bit flipped
    assign buf_addr  = err_byte_q;
    assign buf_rd_en = (state_q == ST_FETCH);
    assign buf_wr_en = (state_q == ST_PATCH);
    assign buf_wdata = buf_rdata ^ (8'd1 << err_bit_q);

    // Status outputs
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_REPORT);
    assign result   = verdict_q;
    assign err_byte = err_byte_q;
    assign err_bit  = err_bit_q;

endmodule

// File: rtl/ecc_fixer_checks.sv
// Property checker for nand_ecc_fixer, attached by the bind below.
// Assumes the buffer read latency of one cycle stated for the top.
module ecc_fixer_checks #(
    parameter int BLK_LOG = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic [1:0]         result,
    input logic [BLK_LOG-1:0] err_byte,
    input logic [2:0]         err_bit,
    input logic [BLK_LOG-1:0] buf_addr,
    input logic               buf_rd_en,
    input logic [7:0]         buf_rdata,
    input logic               buf_wr_en,
    input logic [7:0]         buf_wdata
);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));

    a_r10_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr)));

    a_r6_one_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($countones(buf_wdata ^ buf_rdata) == 1));

    a_r8_report_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> (done && result == 2'b01));

    a_r10_location_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (result != 2'b01) |-> (err_byte == '0 && err_bit == '0));

    a_r10_access_only_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en || buf_wr_en) |-> (busy && result == 2'b01));

endmodule

bind nand_ecc_fixer ecc_fixer_checks #(.BLK_LOG(BLK_LOG)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .err_byte  (err_byte),
    .err_bit   (err_bit),
    .buf_addr  (buf_addr),
    .buf_rd_en (buf_rd_en),
    .buf_rdata (buf_rdata),
    .buf_wr_en (buf_wr_en),
    .buf_wdata (buf_wdata)
);

// File: tb/test_nand_ecc_fixer.sv
// Bench for nand_ecc_fixer: directed corners plus seeded random syndromes.
module test_nand_ecc_fixer;

    localparam int BLK_LOG = 9;
    localparam int NPAIR   = BLK_LOG + 3;
    localparam int CODE_W  = 2 * NPAIR;
    localparam int BLK     = 1 << BLK_LOG;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [CODE_W-1:0]  code_stored = '0;
    logic [CODE_W-1:0]  code_calc = '0;
    logic               busy, done;
    logic [1:0]         result;
    logic [BLK_LOG-1:0] err_byte, buf_addr;
    logic [2:0]         err_bit;
    logic               buf_rd_en, buf_wr_en;
    logic [7:0]         buf_rdata = '0;
    logic [7:0]         buf_wdata;

    logic [7:0] mem    [BLK];
    logic [7:0] shadow [BLK];
    int rd_cnt = 0, wr_cnt = 0;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    nand_ecc_fixer #(.BLK_LOG(BLK_LOG)) i_nand_ecc_fixer (
        .clk, .rst_n, .start, .code_stored, .code_calc, .busy, .done, .result,
        .err_byte, .err_bit, .buf_addr, .buf_rd_en, .buf_rdata, .buf_wr_en, .buf_wdata
    );

    // Buffer model with one-cycle read latency
    always @(posedge clk) begin
        if (buf_rd_en) begin
            buf_rdata <= mem[buf_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (buf_wr_en) begin
            mem[buf_addr] <= buf_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected verdict from the requirements
    function automatic int exp_verdict(input logic [CODE_W-1:0] s, input logic [CODE_W-1:0] c);
        int n;
        n = $countones(s ^ c);
        if (s == c) return 0;
        if (n == 1 || n == NPAIR - 1) return 2;
        if (n == NPAIR) return 1;
        if (s == {CODE_W{1'b1}} && c == '0) return 3;
        return 2;
    endfunction

    // Syndrome of a genuine single-bit error at bit position pos
    function automatic logic [CODE_W-1:0] single_err_syn(input int pos);
        logic [NPAIR-1:0] o, e;
        o = NPAIR'(pos);
        e = ~o;
        return {o[11:8], e[11:8], o[7:0], e[7:0]};
    endfunction

    function automatic logic [CODE_W-1:0] weight_mask(input int n);
        logic [CODE_W-1:0] m;
        m = '0;
        while ($countones(m) < n) m[$urandom % CODE_W] = 1'b1;
        return m;
    endfunction

    task automatic run_case(input logic [CODE_W-1:0] s, input logic [CODE_W-1:0] c, input bit poke);
        int v, n, mism, eb, ek;
        logic [CODE_W-1:0] x;
        v = exp_verdict(s, c);
        x = s ^ c;
        eb = (v == 1) ? int'({x[23:20], x[15:11]}) : 0;
        ek = (v == 1) ? int'(x[10:8]) : 0;
        if (v == 1) shadow[eb] = shadow[eb] ^ (8'd1 << ek);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        code_stored = s; code_calc = c; start = 1'b1;
        @(posedge clk);
        n = 0;
        @(negedge clk);
        start = 1'b0;
        code_stored = $urandom; code_calc = $urandom;
        while (!done && n < 10) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 1) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        // R8: done latency by verdict
        check(n == ((v == 1) ? 3 : 1), "R8 done latency", n, (v == 1) ? 3 : 1);
        // R2 R3 R4 R5 R7: verdict
        check(int'(result) == v, "R2/R3/R4/R5/R7 result", int'(result), v);
        // R5 R10: location
        check(int'(err_byte) == eb && int'(err_bit) == ek, "R5 R10 location",
              int'(err_byte) * 8 + int'(err_bit), eb * 8 + ek);
        @(negedge clk);
        // R10: access counts
        check(rd_cnt == (v == 1 ? 1 : 0) && wr_cnt == (v == 1 ? 1 : 0), "R10 access count",
              rd_cnt * 10 + wr_cnt, (v == 1) ? 11 : 0);
        // R8 R9: done single pulse, no second run
        check(!done && !busy, "R8 R9 idle after done", int'({busy, done}), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            check(!done && !busy, "R9 start while busy ignored", int'({busy, done}), 0);
        end
        // R6: buffer contents
        mism = 0;
        for (int i = 0; i < BLK; i++) if (mem[i] !== shadow[i]) mism++;
        check(mism == 0, "R6 buffer contents", mism, 0);
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < BLK; i++) begin
            mem[i] = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && result == 2'b00 && !buf_rd_en && !buf_wr_en, "R1 reset",
              int'({busy, done, result, buf_rd_en, buf_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && result == 2'b00, "R1 after reset", int'({busy, done, result}), 0);

        // Directed corners
        run_case(24'h5A3C81, 24'h5A3C81, 1'b0);                       // R2 equal
        run_case(24'h000000, 24'h000001, 1'b0);                       // R3 single bit
        run_case(24'h123456, 24'h123456 ^ weight_mask(11), 1'b0);     // R4 eleven bits
        run_case(24'h0F0F0F ^ single_err_syn(0), 24'h0F0F0F, 1'b0);   // R5 offset 0 bit 0
        run_case(24'h000000 ^ single_err_syn(4095), 24'h000000, 1'b0);// R5 offset 511 bit 7
        run_case(24'hFFFFFF, 24'h000000, 1'b0);                       // R7 erased
        run_case(24'hFFFFFF, 24'h000001, 1'b0);                       // R7 near-erased
        run_case(24'hFFFFFF, 24'hFFFFFF ^ single_err_syn(1234), 1'b0);// R5 beats erased
        run_case(24'hABCDEF ^ single_err_syn(777), 24'hABCDEF, 1'b1); // R9 poke while busy

        // Seeded random mix
        for (int t = 0; t < 60; t++) begin
            logic [CODE_W-1:0] c;
            int kind;
            c = CODE_W'($urandom);
            kind = $urandom % 5;
            case (kind)
                0: run_case(c, c, 1'b0);
                1: run_case(c ^ weight_mask(1), c, 1'b0);
                2: run_case(c ^ weight_mask(NPAIR - 1), c, 1'b0);
                3: run_case(c ^ single_err_syn($urandom % (BLK * 8)), c, 1'b0);
                default: run_case(CODE_W'($urandom), c, 1'b0);
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule